// File: doc/BRIEF.md
# DAC Update Sequencing Controller

This block sequences how a precision DAC takes new values. A serial front end delivers finished frames as a one-cycle pulse with an address and a data word. The controller holds three settings: an input code, a signed offset and a fractional gain. Each time one of them is written, it spends a fixed number of clock cycles computing the next output code. During that time it pulls a shared, open-drain busy line low.

The output register does not follow the computation directly. It takes the computed code only when the active-low load strobe falls and the busy line reads high. If the strobe falls while the line is low, the request is held and carried out at the first edge where the line reads high again. The line can be low because of the block's own computation or because another device is holding it down. Settings can still be written while the line is low.

A ready flag tells the host that a frame has been taken. A hardware reset input and a software reset command both restore defaults. A select pin chooses whether those defaults give a midscale or a zero-scale output.

Top module: `dac_seq_ctrl`

## Requirements
- R1: Frame addresses are 0 = input code (unsigned, 18 bit), 1 = offset (18-bit two's complement) and 2 = gain (unsigned, 16 fractional bits, so 0x10000 is unity). The computed code is floor(input*gain/65536) + offset.
- R2: A write to address 0, 1 or 2 makes busy_drive_low high for exactly 4 cycles, starting at the clock edge that accepts the frame. A further write during that time restarts the count.
- R3: A write accepted while the busy line is low still updates its register, and the next computed code uses it.
- R4: dac_code does not change at any clock edge where busy_line is sampled low, except for a reset.
- R5: A falling edge on ldac_n, sampled while busy_line is high, copies the latest computed code to dac_code at that same clock edge.
- R6: A falling edge on ldac_n sampled while busy_line is low is remembered. It is applied at the first later edge where busy_line reads high, whether the line was held by the block's own computation or by an external device.
- R7: ready_n goes low after the edge that accepts a frame. It returns high after the edge that first samples cs_n high following a low. If both happen at the same edge, the frame wins.
- R8: While rst_n is low, busy_drive_low is high and every register takes its default. The input code defaults to 0x20000 when mid_sel=1 and to 0 when mid_sel=0. The offset defaults to 0 and the gain to unity. dac_code takes the same selected default and keeps it after reset until a load.
- R9: A frame to address 7 is a software reset. At that edge it restores the same defaults as R8, including dac_code, and busy_drive_low is high for the following cycle.
- R10: The computed code saturates at 0 when the sum is negative and at 0x3FFFF when the sum is above that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also pulls busy low |
| cs_n | input | 1 | Serial chip select level, used to release ready |
| frame_valid | input | 1 | One-cycle pulse: a decoded frame is present |
| frame_addr | input | 3 | Frame target address |
| frame_data | input | 18 | Frame data word |
| ldac_n | input | 1 | Active-low load strobe (falling edge requests a load) |
| mid_sel | input | 1 | Default select: 1 = midscale, 0 = zero scale |
| busy_in | input | 1 | Sensed level of the shared busy line (low = busy) |
| busy_drive_low | output | 1 | Open-drain enable: 1 pulls the busy line low |
| ready_n | output | 1 | Active-low frame-taken flag |
| dac_code | output | 18 | Code held in the DAC output register |

## Verification
A stale or corrupted setting register appears only at dac_code, and only at the next load after a computation finishes. The bench therefore follows every randomized group of writes with a load and compares the result within a cycle. A wrong busy counter appears directly as a busy window of the wrong length, which the bench counts edge by edge. A lost or early pending load appears as dac_code moving either one edge too soon or not at all after the line rises. The bench samples just before and just after that edge, for both internal and external holds.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_INPUT  = 3'd0,
      REG_OFFSET = 3'd1,
      REG_GAIN   = 3'd2,
      CMD_SWRST  = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/dac_seq_regs.sv
module dac_seq_regs
   import dac_seq_pkg::*;
#(
   parameter int DATA_W    = 18,
   parameter int GAIN_W    = 18,
   parameter int GAIN_FRAC = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [DATA_W-1:0]     dflt_code,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     in_q,
   output logic [DATA_W-1:0]     off_q,
   output logic [GAIN_W-1:0]     gain_q,
   output logic                  data_wr
);
   localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << GAIN_FRAC;

   logic hit_in, hit_off, hit_gain;

   always_comb begin
      hit_in   = wr_en && (wr_addr == REG_INPUT);
      hit_off  = wr_en && (wr_addr == REG_OFFSET);
      hit_gain = wr_en && (wr_addr == REG_GAIN);
      data_wr  = hit_in || hit_off || hit_gain;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         in_q   <= dflt_code;
         off_q  <= '0;
         gain_q <= GAIN_UNITY;
      end else begin
         if (hit_in)   in_q   <= wr_data;
         if (hit_off)  off_q  <= wr_data;
         if (hit_gain) gain_q <= wr_data[GAIN_W-1:0];
      end
   end
endmodule

// File: rtl/dac_seq_calc.sv
module dac_seq_calc #(
   parameter int DATA_W      = 18,
   parameter int GAIN_W      = 18,
   parameter int GAIN_FRAC   = 16,
   parameter int CALC_CYCLES = 4,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [DATA_W-1:0] dflt_code,
   input  logic              start,
   input  logic [DATA_W-1:0] in_q,
   input  logic [DATA_W-1:0] off_q,
   input  logic [GAIN_W-1:0] gain_q,
   output logic              calc_busy,
   output logic [DATA_W-1:0] calc_q
);
   localparam int PROD_W = DATA_W + GAIN_W;
   localparam int SUM_W  = PROD_W + 2;
   localparam int CNT_W  = $clog2(CALC_CYCLES + 1);

   logic [PROD_W-1:0]       prod, scaled;
   logic signed [SUM_W-1:0] sum;
   logic [DATA_W-1:0]       result;
   logic [CNT_W-1:0]        cnt;

   always_comb begin
      prod   = PROD_W'(in_q) * PROD_W'(gain_q);
      scaled = prod >> GAIN_FRAC;
      sum    = $signed({2'b00, scaled})
             + $signed({{(SUM_W-DATA_W){off_q[DATA_W-1]}}, off_q});
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum[SUM_W-1])
               result = '0;
            else if (|sum[SUM_W-2:DATA_W])
               result = '1;
            else
               result = sum[DATA_W-1:0];
         end
      end else begin : g_wrap
         always_comb result = sum[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         cnt       <= '0;
         calc_busy <= 1'b0;
         calc_q    <= dflt_code;
      end else if (start) begin
         cnt       <= CNT_W'(CALC_CYCLES);
         calc_busy <= 1'b1;
      end else if (calc_busy) begin
         cnt <= cnt - CNT_W'(1);
         if (cnt == CNT_W'(1)) begin
            calc_busy <= 1'b0;
            calc_q    <= result;
         end
      end
   end
endmodule

// File: rtl/dac_seq_load.sv
module dac_seq_load #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [DATA_W-1:0] dflt_code,
   input  logic              ldac_n,
   input  logic              line_high,
   input  logic [DATA_W-1:0] calc_q,
   input  logic              cs_n,
   input  logic              frame_valid,
   output logic [DATA_W-1:0] dac_code,
   output logic              ready_n
);
   logic ldac_prev, pending, ldac_fall, cs_prev;

   always_comb ldac_fall = ldac_prev && !ldac_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldac_prev <= 1'b1;
         cs_prev   <= 1'b1;
         ready_n   <= 1'b1;
      end else begin
         ldac_prev <= ldac_n;
         cs_prev   <= cs_n;
         if (frame_valid)
            ready_n <= 1'b0;
         else if (cs_n && !cs_prev)
            ready_n <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         pending  <= 1'b0;
         dac_code <= dflt_code;
      end else if ((ldac_fall || pending) && line_high) begin
         pending  <= 1'b0;
         dac_code <= calc_q;
      end else if (ldac_fall) begin
         pending  <= 1'b1;
      end
   end
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
   import dac_seq_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int GAIN_W      = 18,
   parameter int GAIN_FRAC   = 16,
   parameter int CALC_CYCLES = 4,
   parameter bit SATURATE    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  frame_valid,
   input  logic [REG_ADDR_W-1:0] frame_addr,
   input  logic [DATA_W-1:0]     frame_data,
   input  logic                  ldac_n,
   input  logic                  mid_sel,
   input  logic                  busy_in,
   output logic                  busy_drive_low,
   output logic                  ready_n,
   output logic [DATA_W-1:0]     dac_code
);
   generate
      if (DATA_W < 2)              begin : g_bad_w  $error("DATA_W must be at least 2");        end
      if (GAIN_W > DATA_W)         begin : g_bad_g  $error("GAIN_W must not exceed DATA_W");    end
      if (GAIN_FRAC >= GAIN_W)     begin : g_bad_f  $error("GAIN_FRAC must be below GAIN_W");   end
      if (CALC_CYCLES < 1)         begin : g_bad_c  $error("CALC_CYCLES must be at least 1");   end
   endgenerate

   logic [DATA_W-1:0] dflt_code, in_q, off_q, calc_q;
   logic [GAIN_W-1:0] gain_q;
   logic              soft_rst, data_wr, calc_busy, srst_q;

   always_comb begin
      dflt_code      = {mid_sel, {(DATA_W-1){1'b0}}};
      soft_rst       = rst_n && frame_valid && (frame_addr == CMD_SWRST);
      busy_drive_low = !rst_n || srst_q || calc_busy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= soft_rst;
   end

   dac_seq_regs #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dflt_code(dflt_code),
      .wr_en(frame_valid), .wr_addr(frame_addr), .wr_data(frame_data),
      .in_q(in_q), .off_q(off_q), .gain_q(gain_q), .data_wr(data_wr)
   );

   dac_seq_calc #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
                  .CALC_CYCLES(CALC_CYCLES), .SATURATE(SATURATE)) u_calc (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dflt_code(dflt_code),
      .start(data_wr), .in_q(in_q), .off_q(off_q), .gain_q(gain_q),
      .calc_busy(calc_busy), .calc_q(calc_q)
   );

   dac_seq_load #(.DATA_W(DATA_W)) u_load (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dflt_code(dflt_code),
      .ldac_n(ldac_n), .line_high(busy_in), .calc_q(calc_q),
      .cs_n(cs_n), .frame_valid(frame_valid),
      .dac_code(dac_code), .ready_n(ready_n)
   );
endmodule

// File: rtl/dac_seq_ctrl_chk.sv
module dac_seq_ctrl_chk
   import dac_seq_pkg::*;
#(
   parameter int DATA_W = 18
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cs_n,
   input logic                  frame_valid,
   input logic [REG_ADDR_W-1:0] frame_addr,
   input logic                  mid_sel,
   input logic                  busy_in,
   input logic                  busy_drive_low,
   input logic                  ready_n,
   input logic [DATA_W-1:0]     dac_code
);
   logic is_data_wr, is_swrst;
   always_comb begin
      is_data_wr = frame_valid && (frame_addr == REG_INPUT || frame_addr == REG_OFFSET
                                   || frame_addr == REG_GAIN);
      is_swrst   = frame_valid && (frame_addr == CMD_SWRST);
   end

   assert_busy_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_data_wr |=> busy_drive_low);

   assert_dac_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_in && !is_swrst) |=> $stable(dac_code));

   assert_ready_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !ready_n);

   assert_ready_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs_n) && !frame_valid) |=> ready_n);

   assert_swrst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_swrst && $stable(mid_sel)) |=> (busy_drive_low &&
         dac_code == {mid_sel, {(DATA_W-1){1'b0}}}));

   always_comb begin
      if (!rst_n) assert_busy_in_reset_R8: assert (busy_drive_low);
   end
endmodule

bind dac_seq_ctrl dac_seq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_valid(frame_valid),
   .frame_addr(frame_addr), .mid_sel(mid_sel), .busy_in(busy_in),
   .busy_drive_low(busy_drive_low), .ready_n(ready_n), .dac_code(dac_code)
);

// File: tb/dac_seq_ctrl_tb.sv
module dac_seq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        frame_valid = 1'b0;
   logic [2:0]  frame_addr = '0;
   logic [17:0] frame_data = '0;
   logic        ldac_n = 1'b1;
   logic        mid_sel = 1'b1;
   logic        ext_hold = 1'b0;
   logic        busy_drive_low, ready_n;
   logic [17:0] dac_code;
   wire         busy_line = ~(busy_drive_low | ext_hold);

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [17:0] m_in, m_off, m_gain, m_dac;

   always #5 clk = ~clk;

   dac_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_valid(frame_valid),
      .frame_addr(frame_addr), .frame_data(frame_data), .ldac_n(ldac_n),
      .mid_sel(mid_sel), .busy_in(busy_line), .busy_drive_low(busy_drive_low),
      .ready_n(ready_n), .dac_code(dac_code)
   );

   function automatic logic [17:0] exp_code(logic [17:0] i, logic [17:0] g, logic [17:0] o);
      longint p, s;
      p = (longint'(i) * longint'(g)) >>> 16;
      s = p + longint'($signed(o));
      if (s < 0) return 18'd0;
      if (s > 64'sd262143) return 18'h3FFFF;
      return s[17:0];
   endfunction

   function automatic logic [17:0] dflt(logic m);
      return m ? 18'h20000 : 18'h0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_defaults();
      m_in = dflt(mid_sel); m_off = '0; m_gain = 18'h10000; m_dac = dflt(mid_sel);
   endtask

   task automatic wr(logic [2:0] a, logic [17:0] d);
      @(negedge clk);
      cs_n = 1'b0; frame_valid = 1'b1; frame_addr = a; frame_data = d;
      @(negedge clk);
      frame_valid = 1'b0;
      case (a)
         3'd0: m_in = d;
         3'd1: m_off = d;
         3'd2: m_gain = d;
         3'd7: set_defaults();
         default: ;
      endcase
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 50 && busy_drive_low; k++) @(negedge clk);
   endtask

   task automatic pulse_ldac();
      @(negedge clk); ldac_n = 1'b0;
      @(negedge clk); ldac_n = 1'b1;
   endtask

   task automatic hw_reset(logic m);
      @(negedge clk);
      mid_sel = m; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 busy in reset", busy_drive_low, 1);
      chk("R8 dac default in reset", dac_code, dflt(m));
      chk("R8 ready idle in reset", ready_n, 1);
      rst_n = 1'b1;
      set_defaults();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      // R8: midscale default, held after reset until a load
      hw_reset(1'b1);
      repeat (5) @(negedge clk);
      chk("R8 busy released", busy_drive_low, 0);
      chk("R8 dac holds midscale", dac_code, 18'h20000);

      // R1 R2 R7: single write, busy length and ready handshake
      wr(3'd0, 18'h12345);
      chk("R7 ready low after frame", ready_n, 0);
      begin
         int n = 0;
         for (int k = 0; k < 20 && busy_drive_low; k++) begin n++; @(negedge clk); end
         chk("R2 busy length", n, 4);
      end
      chk("R4 dac unchanged without load", dac_code, 18'h20000);
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk);
      chk("R7 ready high after cs rise", ready_n, 1);
      pulse_ldac();
      m_dac = exp_code(m_in, m_gain, m_off);
      chk("R5 load when idle", dac_code, m_dac);

      // R3 R2: write during busy restarts and is used
      wr(3'd0, 18'h01000);
      wr(3'd2, 18'h18000);
      begin
         int n = 0;
         for (int k = 0; k < 20 && busy_drive_low; k++) begin n++; @(negedge clk); end
         chk("R2 busy restarted by second write", n, 4);
      end
      pulse_ldac();
      m_dac = exp_code(m_in, m_gain, m_off);
      chk("R3 write during busy used", dac_code, m_dac);

      // R6 R4: load during own calculation
      wr(3'd1, 18'h00100);
      ldac_n = 1'b0;
      @(negedge clk); ldac_n = 1'b1;
      chk("R4 no update during calc", dac_code, m_dac);
      wait_idle();
      chk("R4 no update before line high", dac_code, m_dac);
      @(negedge clk);
      m_dac = exp_code(m_in, m_gain, m_off);
      chk("R6 deferred load after calc", dac_code, m_dac);

      // R6 R4: load during external hold
      wr(3'd0, 18'h2ABCD);
      wait_idle();
      @(negedge clk); ext_hold = 1'b1;
      pulse_ldac();
      repeat (6) @(negedge clk);
      chk("R4 no update during external hold", dac_code, m_dac);
      ext_hold = 1'b0;
      @(negedge clk);
      m_dac = exp_code(m_in, m_gain, m_off);
      chk("R6 deferred load after external hold", dac_code, m_dac);

      // R10: saturation both ends
      wr(3'd0, 18'h3FFFF); wr(3'd2, 18'h3FFFF); wr(3'd1, 18'h00000);
      wait_idle(); pulse_ldac();
      chk("R10 saturate high", dac_code, 18'h3FFFF);
      wr(3'd0, 18'h00010); wr(3'd1, 18'h20000);
      wait_idle(); pulse_ldac();
      chk("R10 saturate low", dac_code, 18'h0);

      // R9: software reset with midscale
      wr(3'd7, 18'h0);
      chk("R9 busy after soft reset", busy_drive_low, 1);
      chk("R9 dac midscale after soft reset", dac_code, 18'h20000);
      @(negedge clk);
      chk("R9 busy released", busy_drive_low, 0);
      wr(3'd2, 18'h20000);
      wait_idle(); pulse_ldac();
      chk("R9 input defaulted to midscale", dac_code, exp_code(18'h20000, 18'h20000, 18'h0));

      // R8 R9: zero-scale defaults
      hw_reset(1'b0);
      repeat (3) @(negedge clk);
      chk("R8 dac holds zero scale", dac_code, 18'h0);
      pulse_ldac();
      chk("R8 load of default stays zero", dac_code, 18'h0);
      wr(3'd0, 18'h15555); wait_idle(); pulse_ldac();
      wr(3'd7, 18'h0);
      chk("R9 dac zero after soft reset", dac_code, 18'h0);
      wr(3'd2, 18'h20000); wait_idle(); pulse_ldac();
      chk("R9 input defaulted to zero", dac_code, 18'h0);

      // R1 R5 R7: randomized settings
      for (int it = 0; it < 30; it++) begin
         wr(3'd0, 18'($urandom));
         wr(3'd2, 18'($urandom_range(0, 18'h3FFFF)));
         wr(3'd1, 18'($urandom));
         chk("R7 ready low after random frame", ready_n, 0);
         @(negedge clk); cs_n = 1'b1;
         wait_idle();
         @(negedge clk);
         chk("R7 ready high after random cs rise", ready_n, 1);
         pulse_ldac();
         m_dac = exp_code(m_in, m_gain, m_off);
         chk("R1 random computed code", dac_code, m_dac);
      end

      finish_run();
   end
endmodule